// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Transmitter

This block turns a short packet of bytes into the two-wire differential line signalling of a low-speed serial bus. It runs at ten system clocks per line bit. A start pulse and a byte count launch it. The block generates the leading synchronisation byte by itself, so the count includes that byte and lies between 2 and the configured maximum (12 by default). It then fetches the remaining bytes one at a time through a request pulse. Each bit is NRZI encoded and sent least significant bit first. A stuffed toggle is inserted after every run of six ones. The packet closes with an end-of-packet sequence, and then the block releases the line.

While a packet is on the line, the block holds a drive enable high and reports busy. It also holds the device's active bus address. A new address presented on a side input is adopted in the final phase of the next packet, but only when that packet carries data. A two-byte handshake never changes the address.

Top module: `lsusb_tx`

## Requirements
- R1: After reset the block is idle: drive enable low, busy low, line in the J state (dp_o=0, dm_o=1), no byte request, active address zero.
- R2: A start pulse seen while idle raises busy and drive enable at the next clock edge. The line is then held at J for ten cycles before the first packet bit.
- R3: The synchronisation byte 0x80 is produced internally and needs no request. For a count N, exactly N-1 bytes are requested. Each request is a single-cycle pulse on byte_req_o, and byte_i must be valid in the cycle that follows it.
- R4: Bits leave least significant first and are NRZI encoded. A 0 toggles the line between J (dp_o=0, dm_o=1) and K (dp_o=1, dm_o=0), and a 1 keeps the current state.
- R5: Every line bit, including stuffed ones, lasts exactly ten cycles. There is no gap between consecutive bytes.
- R6: After six consecutive 1 bits, one extra toggle bit is inserted. The run count carries across byte boundaries and also applies after the final byte.
- R7: Right after the last bit, both lines are driven low (SE0) for 20 cycles. J is then driven for 10 cycles. After that, drive enable and busy fall together.
- R8: The pending address on addr_new_i becomes dev_addr_o when the SE0 phase ends, but only if the count was greater than 2. Otherwise dev_addr_o keeps its value.
- R9: A start pulse while busy has no effect on the packet in progress, on its byte requests or on its timing.
- R10: Whenever the drive enable is low, the outputs show J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, ten cycles per line bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a packet |
| nbytes_i | input | 4 | Byte count including the sync byte (2..12), sampled with start_i |
| byte_req_o | output | 1 | Pulse asking for the next packet byte |
| byte_i | input | 8 | Next packet byte, valid the cycle after byte_req_o |
| addr_new_i | input | 7 | Pending device address |
| dev_addr_o | output | 7 | Active device address |
| dp_o | output | 1 | Positive data line level |
| dm_o | output | 1 | Negative data line level |
| oe_o | output | 1 | Line drive enable |
| busy_o | output | 1 | Packet in progress |

## Verification
The bench sweeps every legal count, each with all-ones, all-zeros, alternating and mixed payloads, and compares the lines against an arithmetic model in every cycle. All-ones payloads make stuff bits land at byte edges and after the last byte. A design that reset its run count per byte, or skipped the trailing stuff, would shift the whole tail of the line by one bit time. A late byte fetch shows up as a stretched bit at a byte edge. A miscounted SE0 or J phase shows up as a wrong release cycle. Two-byte packets check that the address does not move after a handshake. A start pulse injected mid-packet with a different count checks that neither the waveform nor the request count changes.

// File: rtl/lsusb_pkg.sv
package lsusb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XMIT = 2'd1,
    ST_SE0  = 2'd2,
    ST_EOPJ = 2'd3
  } tx_st_t;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/lsusb_tick.sv
module lsusb_tick #(
  parameter int DIV = 10,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lsusb_stuff.sv
module lsusb_stuff #(
  parameter int RUN = 6,
  localparam int OW = $clog2(RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic bit_in,
  output logic stuff_due
);
  logic [OW-1:0] ones_q, ones_d;

  assign stuff_due = (ones_q == OW'(RUN));

  always_comb begin
    ones_d = ones_q;
    if (clr) begin
      ones_d = '0;
    end else if (adv) begin
      if (stuff_due)   ones_d = '0;
      else if (bit_in) ones_d = ones_q + OW'(1);
      else             ones_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end
endmodule

// File: rtl/lsusb_line.sv
module lsusb_line (
  input  logic clk,
  input  logic rst_n,
  input  logic set_j,
  input  logic toggle,
  output logic line_k
);
  logic k_q, k_d;

  assign line_k = k_q;

  always_comb begin
    if (set_j)       k_d = 1'b0;
    else if (toggle) k_d = ~k_q;
    else             k_d = k_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) k_q <= 1'b0;
    else        k_q <= k_d;
  end
endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
  import lsusb_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int MAX_BYTES    = 12,
  parameter int ADDR_W       = 7,
  parameter int STUFF_RUN    = 6,
  parameter int SE0_BITS     = 2,
  localparam int CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  output logic              byte_req_o,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] addr_new_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              busy_o
);
  localparam int EW = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1;

  tx_st_t            st_q, st_d;
  logic [7:0]        shr_q, shr_d;
  logic [3:0]        bidx_q, bidx_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              req_q, req_d;
  logic              load_q, load_d;
  logic              data_q, data_d;
  logic [EW-1:0]     eop_q, eop_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  logic tick, stuff_due, line_k;
  logic launch, stuff_slot, set_j, clr_run;

  lsusb_tick #(.DIV(CLKS_PER_BIT)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(st_q != ST_IDLE), .tick(tick)
  );

  lsusb_stuff #(.RUN(STUFF_RUN)) u_stuff (
    .clk(clk), .rst_n(rst_n), .clr(clr_run),
    .adv(launch | stuff_slot), .bit_in(shr_q[0]), .stuff_due(stuff_due)
  );

  lsusb_line u_line (
    .clk(clk), .rst_n(rst_n), .set_j(set_j),
    .toggle(stuff_slot | (launch & ~shr_q[0])), .line_k(line_k)
  );

  always_comb begin
    st_d       = st_q;
    shr_d      = shr_q;
    bidx_d     = bidx_q;
    left_d     = left_q;
    req_d      = 1'b0;
    load_d     = req_q;
    data_d     = data_q;
    eop_d      = eop_q;
    addr_d     = addr_q;
    launch     = 1'b0;
    stuff_slot = 1'b0;
    set_j      = 1'b0;
    clr_run    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_XMIT;
          shr_d   = SYNC_BYTE;
          bidx_d  = '0;
          left_d  = nbytes_i - CNT_W'(1);
          data_d  = (nbytes_i > CNT_W'(2));
          set_j   = 1'b1;
          clr_run = 1'b1;
        end
      end
      ST_XMIT: begin
        if (load_q) begin
          shr_d  = byte_i;
          bidx_d = '0;
          left_d = left_q - CNT_W'(1);
        end
        if (tick) begin
          if (stuff_due) begin
            stuff_slot = 1'b1;
          end else if (!bidx_q[3]) begin
            launch = 1'b1;
            shr_d  = {1'b0, shr_q[7:1]};
            bidx_d = bidx_q + 4'd1;
            req_d  = (bidx_q == 4'd7) && (left_q != '0);
          end else if (left_q == '0) begin
            st_d  = ST_SE0;
            eop_d = '0;
          end
        end
      end
      ST_SE0: begin
        if (tick) begin
          if (eop_q == EW'(SE0_BITS - 1)) begin
            st_d  = ST_EOPJ;
            set_j = 1'b1;
            if (data_q) addr_d = addr_new_i;
          end else begin
            eop_d = eop_q + EW'(1);
          end
        end
      end
      ST_EOPJ: begin
        if (tick) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      shr_q  <= '0;
      bidx_q <= '0;
      left_q <= '0;
      req_q  <= 1'b0;
      load_q <= 1'b0;
      data_q <= 1'b0;
      eop_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      shr_q  <= shr_d;
      bidx_q <= bidx_d;
      left_q <= left_d;
      req_q  <= req_d;
      load_q <= load_d;
      data_q <= data_d;
      eop_q  <= eop_d;
      addr_q <= addr_d;
    end
  end

  logic drive_lvl;
  assign drive_lvl  = (st_q == ST_XMIT || st_q == ST_EOPJ) && line_k;
  assign dp_o       = drive_lvl;
  assign dm_o       = (st_q != ST_SE0) && !drive_lvl;
  assign oe_o       = (st_q != ST_IDLE);
  assign busy_o     = (st_q != ST_IDLE);
  assign byte_req_o = req_q;
  assign dev_addr_o = addr_q;
endmodule

// File: rtl/lsusb_tx_chk.sv
module lsusb_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              byte_req_o,
  input logic [ADDR_W-1:0] dev_addr_o,
  input logic              dp_o,
  input logic              dm_o,
  input logic              oe_o,
  input logic              busy_o
);
  AST_IDLE_J: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (!dp_o && dm_o)); // R10
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req_o |=> !byte_req_o); // R3
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !byte_req_o); // R3
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && oe_o)); // R2
  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> $stable(dev_addr_o)); // R8
  AST_RELEASE_J: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_o) |-> ($past(!dp_o) && $past(dm_o))); // R7
  AST_NO_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_o && dm_o)); // R4
endmodule

bind lsusb_tx lsusb_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_req_o(byte_req_o),
  .dev_addr_o(dev_addr_o), .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o)
);

// File: tb/sim_lsusb_tx.sv
module sim_lsusb_tx;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [3:0] nbytes_i;
  logic       byte_req_o;
  logic [7:0] byte_i;
  logic [6:0] addr_new_i;
  logic [6:0] dev_addr_o;
  logic       dp_o, dm_o, oe_o, busy_o;

  int total = 0;
  int bad   = 0;
  logic [6:0] exp_addr;

  lsusb_tx u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbytes_i(nbytes_i),
    .byte_req_o(byte_req_o), .byte_i(byte_i), .addr_new_i(addr_new_i),
    .dev_addr_o(dev_addr_o), .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [7:0] pat_byte(int pat, int i, int n);
    case (pat)
      0: return 8'hFF;
      1: return 8'h00;
      2: return (i % 2 == 1) ? 8'h55 : 8'hAA;
      default: return 8'((i * 37 + n * 11) ^ 8'h3C);
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_pkt(int n, int pat, logic [6:0] na, bit poke);
    logic [7:0] pk [0:15];
    logic       ek [0:255];
    int s = 0, ones = 0, fi = 1, nreq = 0, last;
    logic lk = 1'b0;
    pk[0] = 8'h80;
    for (int i = 1; i < n; i++) pk[i] = pat_byte(pat, i, n);
    for (int b = 0; b < n; b++) begin
      for (int k = 0; k < 8; k++) begin
        if (!pk[b][k]) lk = ~lk;
        ek[s] = lk;
        s++;
        ones = pk[b][k] ? ones + 1 : 0;
        if (ones == 6) begin
          lk = ~lk;
          ek[s] = lk;
          s++;
          ones = 0;
        end
      end
    end
    last = 45 + 10 * s;
    addr_new_i = na;
    nbytes_i = 4'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < last; c++) begin
      logic [3:0] e;
      string tag;
      if (c < 10) begin
        e = 4'b1101; tag = "R2";
      end else if (c < 10 + 10 * s) begin
        e = {2'b11, ek[(c - 10) / 10], ~ek[(c - 10) / 10]};
        tag = poke ? "R4 R5 R6 R9" : "R4 R5 R6";
      end else if (c < 30 + 10 * s) begin
        e = 4'b1100; tag = "R7";
      end else if (c < 40 + 10 * s) begin
        e = 4'b1101; tag = "R7";
      end else begin
        e = 4'b0001; tag = "R10";
      end
      chk(tag, {busy_o, oe_o, dp_o, dm_o}, e);
      if (byte_req_o) begin
        byte_i = pk[fi & 15];
        fi++;
        nreq++;
      end
      if (poke && c == 25) begin
        start_i = 1'b1;
        nbytes_i = 4'd12;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    chk(poke ? "R3 R9 requests" : "R3 requests", nreq, n - 1);
    if (n > 2) exp_addr = na;
    chk("R8 address", dev_addr_o, exp_addr);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    nbytes_i = 4'd2;
    byte_i = 8'h00;
    addr_new_i = 7'h00;
    exp_addr = 7'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {busy_o, oe_o, dp_o, dm_o, byte_req_o}, 5'b00010);
    chk("R1 addr", dev_addr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 2; n <= 12; n++) begin
      for (int p = 0; p < 4; p++) begin
        run_pkt(n, p, 7'((n * 9 + p * 5 + 1) & 7'h7F), (p == 3));
        repeat (2) @(negedge clk);
      end
    end
    // handshake after data: address must stay
    run_pkt(2, 1, 7'h55, 1'b0);
    run_pkt(12, 0, 7'h2A, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule